// File: doc/BRIEF.md
# Two-Wire Memory Target Read Engine

This block is the serial front end of an 8 KB byte-addressed memory that sits on a two-wire (I2C) bus as a target. It recognises start, repeated-start and stop conditions. It decodes the control byte against a fixed device code and three strap inputs, and acknowledges only its own address. In a write transfer it accepts a two-byte word address followed by data bytes, and each data byte goes out on a simple write port.

A single 13-bit address pointer persists between transactions. It advances after every byte that is read or written. Three kinds of read use it:
- A current-address read resumes one past the last access.
- A random read loads the pointer through the address phase of a write. A repeated start then turns the transfer into a read.
- A sequential read streams one byte after another for as long as the controller acknowledges, wrapping from the top of memory to zero.

The memory side is a synchronous read port with one cycle of latency. Bus inputs are synchronised to the system clock, and the target pulls SDA low through an open-drain enable.

Top module: `i2c_mem_rd_engine`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop the target leaves SDA released (`sda_oe_o` = 0).
- R2: A control byte of the form `1010 s2 s1 s0 rw` is acknowledged when `s2 s1 s0` equals `strap_i[2:0]`. The target pulls SDA low for the ninth SCL pulse of that byte.
- R3: If the device code or strap bits differ, there is no acknowledge. Every later byte up to the next start is ignored: no acknowledge, no memory write and no pointer change.
- R4: The word address arrives high byte first, then low byte. Only the lower 13 bits are kept (upper three bits of the high byte are discarded), and they load the pointer when the low byte is complete.
- R5: Each data byte after the word address is written at the pointer, and the pointer then advances by one. Every address byte and data byte is acknowledged.
- R6: A read control byte with no preceding address phase returns the byte at one past the last accessed address, whether that access was a read or a write.
- R7: A write control byte, then a word address, then a repeated start and a read control byte returns the byte at that word address. No memory write occurs.
- R8: While the controller acknowledges a read byte, the next sequential byte follows. A not-acknowledge releases SDA and ends the read.
- R9: The pointer wraps from 0x1FFF to 0x0000 during sequential access.
- R10: Read data leaves most significant bit first. `sda_oe_o` changes only while SCL is low.
- R11: While reset is held and right after it, SDA is released and neither memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 3 | Device select straps compared with control-byte bits 3..1 |
| mem_addr_o | output | 13 | Memory address, equal to the pointer |
| mem_re_o | output | 1 | Read strobe; data expected one clock later |
| mem_rdata_i | input | 8 | Read data from the memory |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |

## Verification
Bus inputs pass through two synchroniser stages and one edge register, so every reaction to an SCL edge lands about three system clocks after that edge. SCL is held in each phase for several times that latency, which puts every result well inside its phase:
- The acknowledge and each read data bit are sampled in the middle of the following SCL high phase.
- Memory writes and pointer moves are checked only after the closing stop, through the bench memory model and a later current-address read.
- The release of SDA is checked after the stop has settled.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
  } tgt_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_q;

  assign scl_q = scl_sr[STAGES-1];
  assign sda_o = sda_sr[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_q;
      sda_d  <= sda_o;
    end
  end

  assign scl_rise_o = scl_q & ~scl_d;
  assign scl_fall_o = ~scl_q & scl_d;
  assign start_o    = scl_q & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_q & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + AW'(1);  // natural wrap at top of memory
  end
endmodule

// File: rtl/i2c_mem_rd_engine.sv
module i2c_mem_rd_engine
  import i2c_mem_pkg::*;
#(
  parameter int AW = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    strap_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_re_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o
);
  localparam int HI_BITS = AW - 8;

  tgt_state_e st_q, nxt_q;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [3:0] cnt_q;
  logic [7:0] rx_sr, tx_sr, rx_next;
  logic [HI_BITS-1:0] hi_q;
  logic ack_on_q, rd_cap_q, ld_q;
  logic [AW-1:0] ld_val_q;
  logic ctrl_match;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_addr_ptr #(.AW(AW)) i_ptr (
    .clk_i, .rst_ni,
    .load_i(ld_q), .load_val_i(ld_val_q),
    .inc_i(mem_re_o | mem_we_o),
    .ptr_o(mem_addr_o)
  );

  assign rx_next    = {rx_sr[6:0], sda_s};
  assign ctrl_match = (rx_next[7:4] == DEV_CODE) && (rx_next[3:1] == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      nxt_q       <= ST_IDLE;
      cnt_q       <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      hi_q        <= '0;
      ack_on_q    <= 1'b0;
      rd_cap_q    <= 1'b0;
      ld_q        <= 1'b0;
      ld_val_q    <= '0;
      sda_oe_o    <= 1'b0;
      mem_re_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
    end else begin
      mem_re_o <= 1'b0;
      mem_we_o <= 1'b0;
      ld_q     <= 1'b0;
      rd_cap_q <= mem_re_o;
      if (rd_cap_q) tx_sr <= mem_rdata_i;

      if (start_det) begin
        st_q     <= ST_CTRL;
        cnt_q    <= '0;
        ack_on_q <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_CTRL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: if (scl_rise) begin
            rx_sr <= rx_next;
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q[2:0] == 3'd7) begin
              st_q     <= ST_ACK;
              ack_on_q <= 1'b0;
              case (st_q)
                ST_CTRL: begin
                  if (!ctrl_match) st_q <= ST_IDLE;  // not addressed: wait for next start
                  nxt_q    <= rx_next[0] ? ST_RDATA : ST_ADDR_HI;
                  mem_re_o <= ctrl_match & rx_next[0];
                end
                ST_ADDR_HI: begin
                  hi_q  <= rx_next[HI_BITS-1:0];
                  nxt_q <= ST_ADDR_LO;
                end
                ST_ADDR_LO: begin
                  ld_q     <= 1'b1;
                  ld_val_q <= {hi_q, rx_next};
                  nxt_q    <= ST_WDATA;
                end
                default: begin
                  mem_we_o    <= 1'b1;
                  mem_wdata_o <= rx_next;
                  nxt_q       <= ST_WDATA;
                end
              endcase
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_on_q) begin
              sda_oe_o <= 1'b1;
              ack_on_q <= 1'b1;
            end else begin
              ack_on_q <= 1'b0;
              cnt_q    <= '0;
              st_q     <= nxt_q;
              sda_oe_o <= (nxt_q == ST_RDATA) ? ~tx_sr[7] : 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                tx_sr    <= {tx_sr[6:0], 1'b0};
                sda_oe_o <= ~tx_sr[6];
              end
            end
          end
          ST_RACK: if (scl_rise) begin
            if (!sda_s) begin
              // controller acked: fetch next byte, drive it from the coming fall
              mem_re_o <= 1'b1;
              st_q     <= ST_ACK;
              ack_on_q <= 1'b1;
              nxt_q    <= ST_RDATA;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_mem_rd_engine_chk #(
  parameter int AW = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_re_o,
  input logic          mem_we_o
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R5
  wr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> mem_addr_o == $past(mem_addr_o) + AW'(1));

  // R8
  rd_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_addr_o == $past(mem_addr_o) + AW'(1));

  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));

  // R11
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !sda_oe_o && !mem_re_o && !mem_we_o);
endmodule

bind i2c_mem_rd_engine i2c_mem_rd_engine_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_i2c_mem_rd_engine.sv
module test_i2c_mem_rd_engine;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, preload = 1'b1;
  logic sda_oe, mem_re, mem_we;
  logic [12:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;
  logic [7:0] mem [0:8191];
  wire sda_bus = ~(m_low | sda_oe);
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_mem_rd_engine i_i2c_mem_rd_engine (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_wdata_o(mem_wdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13) ^ (a >> 5));
  endfunction

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < 8192; i++) mem[i] <= pat(i);
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    m_low = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    m_low = 1'b0; wq(2 * Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q);
      scl = 1'b1; wq(2 * Q);
      scl = 1'b0; wq(Q);
    end
    m_low = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    ack = ~sda_bus; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] d);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(Q);
      d[i] = sda_bus; wq(Q);
      scl = 1'b0; wq(Q);
    end
    m_low = give_ack; wq(Q);
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    logic a;
    bus_start();
    send(CW, a); chk("R2 write ctrl ack", a, 1);
    send(hi, a); chk("R4 addr hi ack", a, 1);
    send(lo, a); chk("R4 addr lo ack", a, 1);
  endtask

  task automatic t_reset();
    chk("R11 oe in reset", sda_oe, 0);
    chk("R11 strobes in reset", {mem_re, mem_we}, 0);
    preload = 1'b0; rst_n = 1'b1; wq(4);
    chk("R11 oe after reset", sda_oe, 0);
  endtask

  task automatic t_write();
    logic a;
    set_addr(8'h01, 8'h23);
    send(8'h5A, a); chk("R5 data ack", a, 1);
    send(8'h6B, a); chk("R5 data ack 2", a, 1);
    bus_stop();
    chk("R1 oe after stop", sda_oe, 0);
    chk("R5 mem 0x123", mem[13'h123], 8'h5A);
    chk("R5 mem 0x124", mem[13'h124], 8'h6B);
  endtask

  task automatic t_cur_read();
    logic a; logic [7:0] d;
    bus_start();
    send(CR, a); chk("R2 read ctrl ack", a, 1);
    recv(1'b0, d); bus_stop();
    chk("R6 after write", d, pat(13'h125));
    bus_start(); send(CR, a);
    recv(1'b0, d); bus_stop();
    chk("R6 after read", d, pat(13'h126));
    chk("R8 oe released after nack", sda_oe, 0);
  endtask

  task automatic t_rand_seq();
    logic a; logic [7:0] d;
    set_addr(8'h0A, 8'hBC);
    bus_rstart();
    send(CR, a); chk("R7 read ctrl ack", a, 1);
    recv(1'b1, d); chk("R7 R10 first byte", d, pat(13'hABC));
    recv(1'b1, d); chk("R8 second byte", d, pat(13'hABD));
    recv(1'b0, d); chk("R8 third byte", d, pat(13'hABE));
    bus_stop();
    chk("R7 no write", mem[13'hABC], pat(13'hABC));
    bus_start(); send(CR, a); recv(1'b0, d); bus_stop();
    chk("R6 after seq", d, pat(13'hABF));
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    set_addr(8'h1F, 8'hFF);
    bus_rstart(); send(CR, a);
    recv(1'b1, d); chk("R9 top byte", d, pat(13'h1FFF));
    recv(1'b0, d); chk("R9 wrapped byte", d, pat(0));
    bus_stop();
  endtask

  task automatic t_hi_bits();
    logic a; logic [7:0] d;
    set_addr(8'hE0, 8'h10);
    bus_rstart(); send(CR, a);
    recv(1'b0, d); bus_stop();
    chk("R4 upper bits dropped", d, pat(13'h0010));
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d;
    bus_start();
    send(8'hA8, a); chk("R3 strap mismatch nack", a, 0);
    send(8'h00, a); chk("R3 ignored byte", a, 0);
    send(8'h55, a); chk("R3 ignored byte 2", a, 0);
    bus_stop();
    chk("R3 no write", mem[13'h0011], pat(13'h0011));
    bus_start();
    send(8'hBB, a); chk("R3 code mismatch nack", a, 0);
    bus_stop();
    chk("R1 oe idle", sda_oe, 0);
    bus_start(); send(CR, a); recv(1'b0, d); bus_stop();
    chk("R3 pointer untouched", d, pat(13'h0011));
  endtask

  initial begin
    wq(5);
    t_reset();
    t_write();
    t_cur_read();
    t_rand_seq();
    t_wrap();
    t_hi_bits();
    t_mismatch();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule